// File: doc/BRIEF.md
# Variable-Latency Carry-Skip Adder with Prefix Nucleus

This block adds two 32-bit operands and a carry-in, giving a 32-bit sum and a carry-out. Its carry path runs through skip stages. Each outer stage first ripples its bits with an assumed zero carry. It then folds the true incoming carry in through an incrementer, and an AND-OR term forwards the carry past the stage. The middle eight bits form a Brent-Kung prefix nucleus. That nucleus produces its group generate and its all-propagate term before its internal carries. The all-propagate term selects whether the incoming carry skips the nucleus. The same term also predicts that the long carry chain is in use.

A caller raises `start` for one cycle with the operands on `a`, `b` and `cin`. If the prediction is clear, the registered result appears with `valid` after one clock edge. If the prediction is set, the operands are held internally and the adder gets a full second cycle. The result then appears after two edges, with `slow` raised beside `valid`. The control is a two-state machine:
- `ST_IDLE` accepts a start. It goes to `ST_STRETCH` on a predicted-slow start and stays in `ST_IDLE` otherwise.
- `ST_STRETCH` ignores `start` and always returns to `ST_IDLE`.

Top module: `varlat_skip_adder`

## Requirements
- R1: On each `valid` cycle, `{cout, sum}` equals the 33-bit value `a + b + cin` of the accepted operands.
- R2: When the start is accepted and `(a ^ b)` bits 19 down to 12 are not all ones, `valid` is high in the cycle after the start edge, with `slow` low.
- R3: When the start is accepted and `(a ^ b)` bits 19 down to 12 are all ones, `valid` is low after the first edge and high after the second edge, with `slow` high.
- R4: A `start` that arrives while a two-cycle operation is pending is ignored. It produces no result, and the pending operation completes with its own operands.
- R5: `valid` rises only for an accepted start, exactly once per accepted start. `slow` is never high without `valid`.
- R6: After reset, `valid`, `slow`, `cout` and `sum` are all zero.
- R7: A carry generated below bit 12 reaches bit 20 and above correctly when the nucleus propagates across all its bits.
- R8: `sum` and `cout` keep their value in every cycle in which `valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to add the present operands |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Registered sum |
| cout | output | 1 | Registered carry out of bit 31 |
| valid | output | 1 | One-cycle pulse marking a new result |
| slow | output | 1 | High with `valid` when the operation took two cycles |

## Verification
A fast result is due one edge after its start, and a predicted-slow result is due two edges after. The bench works out which applies from bits 19 to 12 of `a ^ b`. It records the due cycle with each expected item. The monitor samples on the falling edge. It takes an item only when `valid` is high and compares the cycle count against the recorded due cycle. An item still queued past its due cycle is reported as late. A `valid` with nothing queued is reported as a stray result. Every idle cycle confirms that the registered result has not changed.

// File: rtl/vlsa_pkg.sv
package vlsa_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_STRETCH = 1'b1
    } vlsa_state_e;
endpackage

// File: rtl/vlsa_ci_stage.sv
// Skip stage: zero-carry ripple, incrementer for the real carry, AND-OR skip.
module vlsa_ci_stage #(
    parameter int W = 4
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    logic [W:0]   rc;
    logic [W-1:0] s_zero;
    logic [W-1:0] prop;
    logic         grp_p;

    assign rc[0] = 1'b0;
    assign prop  = opa ^ opb;

    for (genvar i = 0; i < W; i++) begin : g_rip
        assign s_zero[i] = prop[i] ^ rc[i];
        assign rc[i+1]   = (opa[i] & opb[i]) | (prop[i] & rc[i]);
    end

    assign grp_p = &prop;
    assign s_out = s_zero + {{(W-1){1'b0}}, c_in};
    assign c_out = rc[W] | (grp_p & c_in);
endmodule

// File: rtl/vlsa_bk_nucleus.sv
// Brent-Kung prefix nucleus; all_p doubles as skip select and slow predictor.
module vlsa_bk_nucleus #(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         c_out,
    output logic         all_p
);
    localparam int LG = $clog2(W);

    logic [W-1:0] pre_p;
    logic [W-1:0] pre_g;
    logic [W-1:0] pfx_p;
    logic [W-1:0] pfx_g;
    logic [W-1:0] cy;

    assign pre_p = opa ^ opb;
    assign pre_g = opa & opb;

    always_comb begin
        logic [W-1:0] gp;
        logic [W-1:0] pp;
        gp = pre_g;
        pp = pre_p;
        // up-sweep: longest span finished first
        for (int lv = 0; lv < LG; lv++) begin
            for (int i = (2 << lv) - 1; i < W; i += (2 << lv)) begin
                gp[i] = gp[i] | (pp[i] & gp[i - (1 << lv)]);
                pp[i] = pp[i] & pp[i - (1 << lv)];
            end
        end
        // down-sweep: fill in the intermediate spans
        for (int lv = LG - 2; lv >= 0; lv--) begin
            for (int i = 3 * (1 << lv) - 1; i < W; i += (2 << lv)) begin
                gp[i] = gp[i] | (pp[i] & gp[i - (1 << lv)]);
                pp[i] = pp[i] & pp[i - (1 << lv)];
            end
        end
        pfx_g = gp;
        pfx_p = pp;
    end

    assign cy[0] = c_in;
    for (genvar i = 1; i < W; i++) begin : g_cy
        assign cy[i] = pfx_g[i-1] | (pfx_p[i-1] & c_in);
    end

    assign all_p = pfx_p[W-1];
    assign c_out = all_p ? c_in : pfx_g[W-1];
    assign s_out = pre_p ^ cy;
endmodule

// File: rtl/vlsa_datapath.sv
// Lower skip stages, prefix nucleus, upper skip stages.
module vlsa_datapath #(
    parameter int SEG_W   = 4,
    parameter int LO_SEGS = 3,
    parameter int HI_SEGS = 3,
    parameter int NUC_W   = 8
) (
    input  logic [SEG_W*(LO_SEGS+HI_SEGS)+NUC_W-1:0] opa,
    input  logic [SEG_W*(LO_SEGS+HI_SEGS)+NUC_W-1:0] opb,
    input  logic                                     c_in,
    output logic [SEG_W*(LO_SEGS+HI_SEGS)+NUC_W-1:0] s_out,
    output logic                                     c_out,
    output logic                                     predict
);
    localparam int NUC_LO = SEG_W * LO_SEGS;
    localparam int HI_LO  = NUC_LO + NUC_W;

    logic [LO_SEGS:0] lo_c;
    logic [HI_SEGS:0] hi_c;

    assign lo_c[0] = c_in;

    for (genvar s = 0; s < LO_SEGS; s++) begin : g_lo
        vlsa_ci_stage #(.W(SEG_W)) u_stg (
            .opa  (opa[s*SEG_W +: SEG_W]),
            .opb  (opb[s*SEG_W +: SEG_W]),
            .c_in (lo_c[s]),
            .s_out(s_out[s*SEG_W +: SEG_W]),
            .c_out(lo_c[s+1])
        );
    end

    vlsa_bk_nucleus #(.W(NUC_W)) u_nuc (
        .opa  (opa[NUC_LO +: NUC_W]),
        .opb  (opb[NUC_LO +: NUC_W]),
        .c_in (lo_c[LO_SEGS]),
        .s_out(s_out[NUC_LO +: NUC_W]),
        .c_out(hi_c[0]),
        .all_p(predict)
    );

    for (genvar s = 0; s < HI_SEGS; s++) begin : g_hi
        vlsa_ci_stage #(.W(SEG_W)) u_stg (
            .opa  (opa[HI_LO + s*SEG_W +: SEG_W]),
            .opb  (opb[HI_LO + s*SEG_W +: SEG_W]),
            .c_in (hi_c[s]),
            .s_out(s_out[HI_LO + s*SEG_W +: SEG_W]),
            .c_out(hi_c[s+1])
        );
    end

    assign c_out = hi_c[HI_SEGS];
endmodule

// File: rtl/varlat_skip_adder.sv
module varlat_skip_adder
    import vlsa_pkg::*;
#(
    parameter int SEG_W   = 4,
    parameter int LO_SEGS = 3,
    parameter int HI_SEGS = 3,
    parameter int NUC_W   = 8,
    localparam int DW     = SEG_W * (LO_SEGS + HI_SEGS) + NUC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          valid,
    output logic          slow
);
    vlsa_state_e   state, state_nx;
    logic [DW-1:0] held_a, held_b;
    logic          held_c;
    logic [DW-1:0] op_a, op_b;
    logic          op_c;
    logic [DW-1:0] dp_sum;
    logic          dp_cout;
    logic          dp_pred;
    logic          in_stretch;

    assign in_stretch = (state == ST_STRETCH);
    assign op_a = in_stretch ? held_a : a;
    assign op_b = in_stretch ? held_b : b;
    assign op_c = in_stretch ? held_c : cin;

    vlsa_datapath #(
        .SEG_W  (SEG_W),
        .LO_SEGS(LO_SEGS),
        .HI_SEGS(HI_SEGS),
        .NUC_W  (NUC_W)
    ) u_dp (
        .opa    (op_a),
        .opb    (op_b),
        .c_in   (op_c),
        .s_out  (dp_sum),
        .c_out  (dp_cout),
        .predict(dp_pred)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start && dp_pred) state_nx = ST_STRETCH;
            ST_STRETCH: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum    <= '0;
            cout   <= 1'b0;
            valid  <= 1'b0;
            slow   <= 1'b0;
            held_a <= '0;
            held_b <= '0;
            held_c <= 1'b0;
        end else begin
            valid <= 1'b0;
            slow  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start && !dp_pred) begin
                        sum   <= dp_sum;
                        cout  <= dp_cout;
                        valid <= 1'b1;
                    end else if (start) begin
                        held_a <= a;
                        held_b <= b;
                        held_c <= cin;
                    end
                end
                ST_STRETCH: begin
                    sum   <= dp_sum;
                    cout  <= dp_cout;
                    valid <= 1'b1;
                    slow  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vlsa_checker.sv
module vlsa_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pred,
    input logic          in_stretch,
    input logic          valid,
    input logic          slow,
    input logic [DW-1:0] sum,
    input logic          cout
);
    AST_FAST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_stretch && !pred) |=> (valid && !slow)); // R2

    AST_SLOW_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !in_stretch && pred) |=> (!valid && in_stretch)); // R3

    AST_STRETCH_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        in_stretch |=> (valid && slow && !in_stretch)); // R3

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !slow) |-> $past(start)); // R5

    AST_SLOW_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        slow |-> valid); // R5

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(sum) && $stable(cout))); // R8

    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stretch && start) |=> !in_stretch); // R4
endmodule

bind varlat_skip_adder vlsa_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pred      (dp_pred),
    .in_stretch(in_stretch),
    .valid     (valid),
    .slow      (slow),
    .sum       (sum),
    .cout      (cout)
);

// File: tb/varlat_skip_adder_test.sv
module varlat_skip_adder_test;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] s;
        logic        co;
        logic        sl;
        int          due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        cin_i = 1'b0;
    logic [31:0] sum_o;
    logic        cout_o, valid_o, slow_o;

    exp_t        q[$];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    logic [31:0] last_s = '0;
    logic        last_co = 1'b0;
    bit          mon_on = 1'b0;
    bit          done = 1'b0;

    varlat_skip_adder uut (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start_i),
        .a    (a_i),
        .b    (b_i),
        .cin  (cin_i),
        .sum  (sum_o),
        .cout (cout_o),
        .valid(valid_o),
        .slow (slow_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // driver: called at a falling edge
    task automatic issue(input logic [31:0] ia, input logic [31:0] ib, input logic ic,
                         input bit accept, input bit settle, input string tag);
        exp_t        e;
        logic [32:0] t;
        logic [31:0] x;
        a_i = ia; b_i = ib; cin_i = ic; start_i = 1'b1;
        x = ia ^ ib;
        e.sl = &x[19:12];
        if (accept) begin
            t     = {1'b0, ia} + {1'b0, ib} + {32'd0, ic};
            e.s   = t[31:0];
            e.co  = t[32];
            e.due = cyc + (e.sl ? 2 : 1);
            e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        start_i = 1'b0;
        if (accept && e.sl && settle) @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (valid_o) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5 stray valid", 64'(valid_o), 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk({cout_o, sum_o} == {e.co, e.s}, {e.tag, " R1 sum"},
                        64'({cout_o, sum_o}), 64'({e.co, e.s}));
                    chk(cyc == e.due, e.sl ? "R3 latency" : "R2 latency", 64'(cyc), 64'(e.due));
                    chk(slow_o == e.sl, e.sl ? "R3 slow flag" : "R2 slow flag", 64'(slow_o), 64'(e.sl));
                end
                last_s  = sum_o;
                last_co = cout_o;
            end else begin
                chk({cout_o, sum_o} == {last_co, last_s}, "R8 hold", 64'({cout_o, sum_o}),
                    64'({last_co, last_s}));
                chk(!slow_o, "R5 slow without valid", 64'(slow_o), 64'd0);
                if (q.size() > 0 && cyc > q[0].due)
                    chk(1'b0, "R2/R3 late result", 64'(cyc), 64'(q[0].due));
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        lf = 32'hACE1_2345;
        repeat (3) @(negedge clk);
        // R6: reset state
        chk(!valid_o, "R6 valid", 64'(valid_o), 64'd0);
        chk(!slow_o, "R6 slow", 64'(slow_o), 64'd0);
        chk(sum_o == 32'd0 && !cout_o, "R6 sum", 64'({cout_o, sum_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        issue(32'd0, 32'd0, 1'b0, 1, 1, "zero");
        issue(32'hFFFF_FFFF, 32'd1, 1'b0, 1, 1, "wrap");
        issue(32'h000F_F000, 32'h000F_F000, 1'b1, 1, 1, "nucleus generate");
        issue(32'hFFFF_FFFF, 32'd0, 1'b1, 1, 1, "R7 full propagate");
        issue(32'h000F_F800, 32'h0000_0800, 1'b0, 1, 1, "R7 skip into upper");
        issue(32'h1234_5678, 32'h0FED_CBA9, 1'b1, 1, 1, "fast");
        // back-to-back fast starts
        issue(32'd2159, 32'd9542, 1'b0, 1, 1, "b2b0");
        issue(32'd2159, 32'd9542, 1'b1, 1, 1, "b2b1");
        issue(32'd325, 32'd438, 1'b0, 1, 1, "b2b2");

        // R4: a start during the stretch is ignored
        issue(32'h0000_F000, 32'h000F_0000, 1'b1, 1, 0, "R4 pending op");
        issue(32'h7777_7777, 32'h1111_1111, 1'b0, 0, 0, "R4 ignored");
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R4 queue drained", 64'(q.size()), 64'd0);
        chk(sum_o == 32'h000F_F001, "R4 result kept", 64'(sum_o), 64'h000F_F001);

        for (int k = 0; k < 48; k++) begin
            logic [31:0] ra, rb;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            ra = lf;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            rb = lf;
            if (k % 3 == 0) rb[19:12] = ~ra[19:12];
            issue(ra, rb, lf[5], 1, 1, "pattern");
        end
        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R5 all results seen", 64'(q.size()), 64'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule